// File: doc/BRIEF.md
# Self-Allocating Associative Lookup Table

This block is a small associative table of `ENTRIES` slots. Each slot holds one data word and an occupied flag. Software-free hardware clients use it as a lookup table. They store a word without naming a location, and they find it again by its contents.

A store request carries only the word. The table places it in the lowest-numbered empty slot and reports on the next clock either the slot it used or a rejection because every slot was taken. A lookup request carries a key and a compare mask. Every occupied slot is compared against the key in parallel, using only the bit positions the mask selects. One clock later the table returns a hit flag, the lowest matching slot number, that slot's word, and a flag that says more than one slot matched. A slot can be freed by its number with a separate release request.

Top module: `cam_alloc`

## Requirements
- R1: While reset is applied, and on the first sampled cycle after it, every slot is empty and `wr_ack`, `wr_rej`, `rsp_valid`, `hit`, `multi` and `full` are all 0.
- R2: A store (`wr_en`=1) with at least one empty slot writes `wr_data` into the lowest-numbered empty slot and marks it occupied. On the next cycle `wr_ack`=1, `wr_rej`=0 and `wr_slot` gives that slot number.
- R3: A store while every slot is occupied (and no release in the same cycle) changes no slot. On the next cycle `wr_rej`=1, `wr_ack`=0 and `wr_slot`=0. `full` is 1 whenever every slot is occupied.
- R4: `rsp_valid` is 1 exactly in the cycle after a cycle with `srch_en`=1. When `rsp_valid` is 0, `hit`, `multi`, `hit_idx` and `hit_data` are all 0.
- R5: A slot matches a lookup when it is occupied and equals `srch_key` on every bit where `srch_mask` is 1. On a hit, `hit_data` is the word stored in the reported slot and `hit_idx` is its number.
- R6: Bit positions where `srch_mask` is 0 take no part in the compare. An all-zero mask matches every occupied slot.
- R7: When several slots match, the lowest-numbered one is reported and `multi`=1. With exactly one match, `multi`=0.
- R8: Empty slots never match. A lookup with no match returns `hit`=0, `hit_idx`=0 and `hit_data`=0.
- R9: A release (`inv_en`=1) empties slot `inv_idx`. A release and a store in the same cycle apply the release first, so the store may use the slot just freed.
- R10: A lookup in the same cycle as a store or release compares against the contents as they were before that cycle's changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Store request |
| wr_data | input | WIDTH | Word to store |
| inv_en | input | 1 | Release request |
| inv_idx | input | $clog2(ENTRIES) | Slot to release |
| srch_en | input | 1 | Lookup request |
| srch_key | input | WIDTH | Lookup key |
| srch_mask | input | WIDTH | 1 = bit takes part in compare |
| wr_ack | output | 1 | Previous-cycle store was accepted |
| wr_rej | output | 1 | Previous-cycle store was rejected, table full |
| wr_slot | output | $clog2(ENTRIES) | Slot used by the accepted store, else 0 |
| full | output | 1 | Every slot is occupied |
| rsp_valid | output | 1 | Lookup result present |
| hit | output | 1 | Lookup found a match |
| multi | output | 1 | More than one slot matched |
| hit_idx | output | $clog2(ENTRIES) | Lowest matching slot |
| hit_data | output | WIDTH | Word stored in that slot |

## Verification
Store results (`wr_ack`, `wr_rej`, `wr_slot`) and lookup results (`rsp_valid`, `hit`, `multi`, `hit_idx`, `hit_data`) each pass through a single register, so they are due one clock after the request. `full` follows the occupied flags, which also update at that edge. The bench applies a request just after a falling edge. A behavioural model then computes every expected value from the table contents before that rising edge, and the outputs are compared at the next falling edge, in the one cycle where the results are due. Cycles with no request are compared the same way, which confirms that results drop back to zero.

// File: rtl/cam_rst_sync.sv
module cam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cam_lowest.sv
module cam_lowest #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cam_match.sv
module cam_match #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0]        valid,
  input  logic [N-1:0][W-1:0] entries,
  input  logic [W-1:0]        key,
  input  logic [W-1:0]        mask,
  output logic [N-1:0]        match
);
  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign match[e] = valid[e] && (((entries[e] ^ key) & mask) == '0);
  end
endmodule

// File: rtl/cam_alloc.sv
module cam_alloc #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 16,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             inv_en,
  input  logic [IW-1:0]    inv_idx,
  input  logic             srch_en,
  input  logic [WIDTH-1:0] srch_key,
  input  logic [WIDTH-1:0] srch_mask,
  output logic             wr_ack,
  output logic             wr_rej,
  output logic [IW-1:0]    wr_slot,
  output logic             full,
  output logic             rsp_valid,
  output logic             hit,
  output logic             multi,
  output logic [IW-1:0]    hit_idx,
  output logic [WIDTH-1:0] hit_data
);
  logic rst_sn;

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][WIDTH-1:0] mem_q;
  logic [ENTRIES-1:0]            inv_vec, kept, wr_vec, match_vec;
  logic                          free_found, any_match, wr_take;
  logic [IW-1:0]                 free_idx, match_idx;

  logic             ack_d, rej_d, rv_d, hit_d, multi_d;
  logic [IW-1:0]    slot_d, idx_d;
  logic [WIDTH-1:0] data_d;

  cam_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // release applies before allocation
  always_comb begin
    inv_vec = inv_en ? (ENTRIES'(1) << inv_idx) : '0;
    kept    = valid_q & ~inv_vec;
  end

  cam_lowest #(.N(ENTRIES)) u_free (
    .req(~kept), .found(free_found), .idx(free_idx)
  );

  cam_match #(.N(ENTRIES), .W(WIDTH)) u_match (
    .valid(valid_q), .entries(mem_q), .key(srch_key), .mask(srch_mask),
    .match(match_vec)
  );

  cam_lowest #(.N(ENTRIES)) u_first (
    .req(match_vec), .found(any_match), .idx(match_idx)
  );

  // next-state logic
  always_comb begin
    wr_take = wr_en & free_found;
    wr_vec  = wr_take ? (ENTRIES'(1) << free_idx) : '0;
    valid_d = kept | wr_vec;

    ack_d   = wr_take;
    rej_d   = wr_en & ~free_found;
    slot_d  = wr_take ? free_idx : '0;

    rv_d    = srch_en;
    hit_d   = srch_en & any_match;
    multi_d = hit_d & (|(match_vec & (match_vec - ENTRIES'(1))));
    idx_d   = hit_d ? match_idx : '0;
    data_d  = hit_d ? mem_q[match_idx] : '0;
  end

  // state and result registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      valid_q   <= '0;
      wr_ack    <= 1'b0;
      wr_rej    <= 1'b0;
      wr_slot   <= '0;
      rsp_valid <= 1'b0;
      hit       <= 1'b0;
      multi     <= 1'b0;
      hit_idx   <= '0;
      hit_data  <= '0;
    end else begin
      valid_q   <= valid_d;
      wr_ack    <= ack_d;
      wr_rej    <= rej_d;
      wr_slot   <= slot_d;
      rsp_valid <= rv_d;
      hit       <= hit_d;
      multi     <= multi_d;
      hit_idx   <= idx_d;
      hit_data  <= data_d;
    end
  end

  // word storage, one clock enable per slot, no reset
  for (genvar e = 0; e < ENTRIES; e++) begin : g_store
    always_ff @(posedge clk) begin
      if (wr_vec[e]) mem_q[e] <= wr_data;
    end
  end

  assign full = &valid_q;

  a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    srch_en |=> rsp_valid);
  a_r4_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    !srch_en |=> (!rsp_valid && !hit && !multi));
  a_r3_reject_full: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && (&valid_q) && !inv_en) |=> (wr_rej && !wr_ack));
  a_r2_ack_excl: assert property (@(posedge clk) disable iff (!rst_sn)
    !(wr_ack && wr_rej));
  a_r2_slot_taken: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_ack |-> valid_q[wr_slot]);
  a_r7_multi_hit: assert property (@(posedge clk) disable iff (!rst_sn)
    multi |-> hit);
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    !hit |-> (hit_idx == '0 && hit_data == '0));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_sn)
    (inv_en && !wr_en) |=> !valid_q[$past(inv_idx)]);
endmodule

// File: tb/tb_cam_alloc.sv
module tb_cam_alloc;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, inv_en, srch_en;
  logic [W-1:0] wr_data, srch_key, srch_mask;
  logic [IW-1:0] inv_idx;
  logic wr_ack, wr_rej, full, rsp_valid, hit, multi;
  logic [IW-1:0] wr_slot, hit_idx;
  logic [W-1:0] hit_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit         mv [N];
  logic [W-1:0] md [N];

  always #4 clk = ~clk;

  cam_alloc #(.ENTRIES(N), .WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .inv_en(inv_en), .inv_idx(inv_idx), .srch_en(srch_en),
    .srch_key(srch_key), .srch_mask(srch_mask), .wr_ack(wr_ack),
    .wr_rej(wr_rej), .wr_slot(wr_slot), .full(full), .rsp_valid(rsp_valid),
    .hit(hit), .multi(multi), .hit_idx(hit_idx), .hit_data(hit_data)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word(int i);
    return {8'h3C, 4'(i), 4'(15 - i)};
  endfunction

  // one request cycle: drive, model, compare one clock later
  task automatic cyc(string tag, bit we, logic [W-1:0] wd, bit ie, int ii,
                     bit se, logic [W-1:0] k, logic [W-1:0] m);
    bit e_hit = 0, e_multi = 0, e_ack = 0, e_rej = 0, e_full = 1;
    int e_idx = 0, e_slot = 0, cnt = 0;
    logic [W-1:0] e_dat = '0;
    wr_en = we; wr_data = wd; inv_en = ie; inv_idx = IW'(ii);
    srch_en = se; srch_key = k; srch_mask = m;
    if (se) begin
      for (int i = 0; i < N; i++) begin
        if (mv[i] && (((md[i] ^ k) & m) == '0)) begin
          if (cnt == 0) begin e_hit = 1; e_idx = i; e_dat = md[i]; end
          cnt++;
        end
      end
    end
    e_multi = (cnt > 1);
    if (ie) mv[ii] = 0;
    if (we) begin
      e_rej = 1;
      for (int i = 0; i < N; i++) begin
        if (!mv[i] && e_rej) begin
          e_rej = 0; e_ack = 1; e_slot = i; mv[i] = 1; md[i] = wd;
        end
      end
    end
    for (int i = 0; i < N; i++) if (!mv[i]) e_full = 0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; inv_en = 0; srch_en = 0;
    chk(tag, "rsp_valid", rsp_valid, se);
    chk(tag, "hit", hit, e_hit);
    chk(tag, "multi", multi, e_multi);
    chk(tag, "hit_idx", hit_idx, e_idx);
    chk(tag, "hit_data", hit_data, e_dat);
    chk(tag, "wr_ack", wr_ack, e_ack);
    chk(tag, "wr_rej", wr_rej, e_rej);
    chk(tag, "wr_slot", wr_slot, e_slot);
    chk(tag, "full", full, e_full);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; md[i] = '0; end
    rst_n = 0; wr_en = 0; inv_en = 0; srch_en = 0;
    wr_data = '0; inv_idx = '0; srch_key = '0; srch_mask = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    chk("R1", "full", full, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "wr_ack", wr_ack, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "wr_rej", wr_rej, 0);
    chk("R1", "hit", hit, 0);
    chk("R1", "multi", multi, 0);
    // R1: empty table gives no hit for all-zero mask
    cyc("R1", 0, '0, 0, 0, 1, '0, '0);
    // R2: fill every slot in order
    for (int i = 0; i < N; i++) cyc("R2", 1, word(i), 0, 0, 0, '0, '0);
    // R3: store into a full table is rejected, word not present
    cyc("R3", 1, 16'hBEEF, 0, 0, 0, '0, '0);
    cyc("R3", 0, '0, 0, 0, 1, 16'hBEEF, 16'hFFFF);
    // R4: idle cycle, no result
    cyc("R4", 0, '0, 0, 0, 0, word(1), 16'hFFFF);
    // R5: exact lookups, single match
    for (int i = 0; i < N; i++) cyc("R5", 0, '0, 0, 0, 1, word(i), 16'hFFFF);
    // R6: masked nibble selects slot 5 only, other bits garbage
    cyc("R6", 0, '0, 0, 0, 1, 16'hA95A, 16'h00F0);
    cyc("R6", 0, '0, 0, 0, 1, 16'h1234, 16'h0000);
    // R7: shared upper byte matches all, lowest reported
    cyc("R7", 0, '0, 0, 0, 1, 16'h3C77, 16'hFF00);
    // R9: release slot 3, then R8 lookup misses it
    cyc("R9", 0, '0, 1, 3, 0, '0, '0);
    cyc("R8", 0, '0, 0, 0, 1, word(3), 16'hFFFF);
    // R2: next store lands in freed slot 3
    cyc("R2", 1, 16'h7777, 0, 0, 0, '0, '0);
    // R9: release and store together on a full table
    cyc("R9", 1, 16'h5555, 1, 5, 0, '0, '0);
    cyc("R9", 0, '0, 0, 0, 1, 16'h5555, 16'hFFFF);
    // R10: lookup sees pre-release contents, then miss
    cyc("R10", 0, '0, 1, 2, 1, word(2), 16'hFFFF);
    cyc("R10", 0, '0, 0, 0, 1, word(2), 16'hFFFF);
    // R10: lookup in same cycle as store does not see the new word
    cyc("R10", 1, 16'h4242, 0, 0, 1, 16'h4242, 16'hFFFF);
    cyc("R10", 0, '0, 0, 0, 1, 16'h4242, 16'hFFFF);
    // R8: empty every slot, nothing matches
    for (int i = 0; i < N; i++) cyc("R8", 0, '0, 1, i, 0, '0, '0);
    cyc("R8", 0, '0, 0, 0, 1, '0, '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule